// File: doc/BRIEF.md
# Stereo Fade, Attenuate and Mute Gain Stage

This block scales a stereo stream of signed 20-bit audio samples by a 10-bit gain. The gain is read as a fraction `gain/1024`. While fading is enabled, the working gain moves toward a programmed target level by one LSB at a time. The spacing between moves is a programmed number of sample strobes. When fading is disabled, the working gain stays where it is. The same gain scales the left and the right sample.

Two controls act after the gain. A fixed attenuation of about 12 dB is an arithmetic right shift by two. A mute forces both outputs to zero and takes precedence over attenuation.

Samples arrive with a one-cycle valid strobe. The scaled pair appears one clock later, with its own one-cycle valid. The control fields come straight from a register file and may change at any time.

Top module: `fade_gain_stage`

## Requirements
- R1: After reset, both sample outputs are 0, the output valid is low, and the working gain is 1023.
- R2: A strobe on `smp_vld_i` produces `smp_vld_o` high in the next cycle, together with the scaled pair. Without a strobe the sample outputs hold their values and `smp_vld_o` is low.
- R3: Each output equals `sample * gain / 1024` truncated toward zero, where `gain` is the working gain before that strobe's step. Left and right use the same gain, so a non-negative input never gives a negative output.
- R4: With fading enabled and the working gain different from the target, the gain moves by exactly one LSB toward the target. The move happens on every `fade_rate_i`-th strobe, counted from the last move or from the last time stepping was idle. The sample on the stepping strobe still uses the old gain.
- R5: A `fade_rate_i` of 0 behaves as 1, so the gain steps on every strobe.
- R6: Once the working gain equals `fade_level_i`, it stays there for as long as the target is unchanged.
- R7: With `fade_en_i` at 0, the working gain keeps its value across strobes and the step count restarts.
- R8: With `atten_i` at 1 and `mute_i` at 0, each output is the R3 result shifted right arithmetically by two bits. For a negative value this rounds toward minus infinity.
- R9: With `mute_i` at 1, both outputs are 0 whatever `atten_i` is, and the ramp keeps running.
- R10: The ramp works in both directions: the gain decreases toward a lower target and increases toward a higher one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld_i | input | 1 | One-cycle strobe marking a new stereo sample |
| smp_l_i | input | 20 | Left sample, two's complement |
| smp_r_i | input | 20 | Right sample, two's complement |
| fade_en_i | input | 1 | 1 lets the gain ramp toward the target |
| fade_rate_i | input | 10 | Strobes per gain step (0 acts as 1) |
| fade_level_i | input | 10 | Target gain |
| atten_i | input | 1 | 1 applies the two-bit arithmetic shift |
| mute_i | input | 1 | 1 forces both outputs to 0 |
| smp_vld_o | output | 1 | Strobe marking a valid output pair |
| smp_l_o | output | 20 | Scaled left sample |
| smp_r_o | output | 20 | Scaled right sample |

## Verification
The assertions assume that `smp_vld_i` is a clean synchronous strobe. They also assume that the control fields are sampled only on the strobe cycle, so a field that changes between strobes affects nothing until the next strobe. The bench keeps to this by changing controls and samples only on falling edges. It drives each strobe for exactly one cycle, leaves idle cycles between strobes, and compares outputs only after the registered pair has settled.

// File: rtl/fade_pkg.sv
package fade_pkg;

    localparam int unsigned SAMPLE_W = 20;
    localparam int unsigned GAIN_W   = 10;
    localparam int unsigned RATE_W   = 10;
    localparam int unsigned N_CHAN   = 2;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic        [GAIN_W-1:0]   gain_t;
    typedef logic        [RATE_W-1:0]   rate_t;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;

endpackage

// File: rtl/fade_step_ctrl.sv
module fade_step_ctrl
    import fade_pkg::*;
#(
    parameter int unsigned GW       = GAIN_W,
    parameter int unsigned RW       = RATE_W,
    parameter logic [GW-1:0] GAIN_INIT = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_i,
    input  logic          enable_i,
    input  logic [RW-1:0] rate_i,
    input  logic [GW-1:0] target_i,
    output logic [GW-1:0] gain_o
);

    typedef struct packed {
        logic [RW-1:0] cnt;
        logic [GW-1:0] gain;
    } ramp_state_t;

    ramp_state_t state_d, state_q;
    step_dir_e   dir;
    logic [RW:0] rate_eff;
    logic [RW:0] cnt_next;
    logic        step_due;

    always_comb begin
        state_d  = state_q;
        rate_eff = (rate_i == '0) ? (RW+1)'(1) : {1'b0, rate_i};
        cnt_next = {1'b0, state_q.cnt} + (RW+1)'(1);
        step_due = (cnt_next >= rate_eff);

        if (!enable_i || state_q.gain == target_i) begin
            dir = DIR_HOLD;
        end else if (state_q.gain < target_i) begin
            dir = DIR_UP;
        end else begin
            dir = DIR_DOWN;
        end

        if (strobe_i) begin
            if (dir == DIR_HOLD) begin
                state_d.cnt = '0;
            end else if (step_due) begin
                state_d.cnt = '0;
                if (dir == DIR_UP) begin
                    state_d.gain = state_q.gain + GW'(1);
                end else begin
                    state_d.gain = state_q.gain - GW'(1);
                end
            end else begin
                state_d.cnt = cnt_next[RW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.cnt  <= '0;
            state_q.gain <= GAIN_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    assign gain_o = state_q.gain;

    // R4
    gain_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.gain != $past(state_q.gain)) |->
            ((state_q.gain == $past(state_q.gain) + GW'(1)) ||
             (state_q.gain == $past(state_q.gain) - GW'(1))));

    // R4
    gain_moves_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.gain != $past(state_q.gain)) |-> $past(strobe_i));

    // R7
    gain_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enable_i) |-> (state_q.gain == $past(state_q.gain)));

    // R6
    gain_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q.gain == target_i) |-> (state_q.gain == $past(state_q.gain)));

endmodule

// File: rtl/fade_chan_scale.sv
module fade_chan_scale
    import fade_pkg::*;
#(
    parameter int unsigned SW = SAMPLE_W,
    parameter int unsigned GW = GAIN_W
) (
    input  logic signed [SW-1:0] sample_i,
    input  logic        [GW-1:0] gain_i,
    input  logic                 atten_i,
    input  logic                 mute_i,
    output logic signed [SW-1:0] sample_o
);

    localparam int unsigned PW = SW + GW + 1;
    localparam logic signed [PW-1:0] TRUNC_BIAS = PW'((1 << GW) - 1);

    logic signed [PW-1:0] s_ext;
    logic signed [PW-1:0] g_ext;
    logic signed [PW-1:0] product;
    logic signed [PW-1:0] biased;
    logic signed [PW-1:0] unused_shifted;
    logic signed [SW-1:0] gained;
    logic signed [SW-1:0] shifted2;

    always_comb begin
        s_ext   = {{(GW+1){sample_i[SW-1]}}, sample_i};
        g_ext   = {{(SW+1){1'b0}}, gain_i};
        product = s_ext * g_ext;
        biased  = product[PW-1] ? (product + TRUNC_BIAS) : product;
        unused_shifted = biased >>> GW;
        gained  = unused_shifted[SW-1:0];
        shifted2 = gained >>> 2;

        if (mute_i) begin
            sample_o = '0;
        end else if (atten_i) begin
            sample_o = shifted2;
        end else begin
            sample_o = gained;
        end
    end

endmodule

// File: rtl/fade_gain_stage.sv
module fade_gain_stage
    import fade_pkg::*;
#(
    parameter int unsigned SW = SAMPLE_W,
    parameter int unsigned GW = GAIN_W,
    parameter int unsigned RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld_i,
    input  logic [SW-1:0] smp_l_i,
    input  logic [SW-1:0] smp_r_i,
    input  logic          fade_en_i,
    input  logic [RW-1:0] fade_rate_i,
    input  logic [GW-1:0] fade_level_i,
    input  logic          atten_i,
    input  logic          mute_i,
    output logic          smp_vld_o,
    output logic [SW-1:0] smp_l_o,
    output logic [SW-1:0] smp_r_o
);

    localparam int unsigned NC = N_CHAN;

    typedef struct packed {
        logic          vld;
        logic [SW-1:0] l;
        logic [SW-1:0] r;
    } out_state_t;

    out_state_t out_d, out_q;
    logic [GW-1:0] gain_cur;
    logic [SW-1:0] chan_in  [NC];
    logic [SW-1:0] chan_out [NC];

    fade_step_ctrl #(
        .GW       (GW),
        .RW       (RW),
        .GAIN_INIT({GW{1'b1}})
    ) i_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe_i(smp_vld_i),
        .enable_i(fade_en_i),
        .rate_i  (fade_rate_i),
        .target_i(fade_level_i),
        .gain_o  (gain_cur)
    );

    assign chan_in[0] = smp_l_i;
    assign chan_in[1] = smp_r_i;

    for (genvar c = 0; c < NC; c++) begin : g_chan
        fade_chan_scale #(
            .SW(SW),
            .GW(GW)
        ) i_scale (
            .sample_i(chan_in[c]),
            .gain_i  (gain_cur),
            .atten_i (atten_i),
            .mute_i  (mute_i),
            .sample_o(chan_out[c])
        );
    end

    always_comb begin
        out_d     = out_q;
        out_d.vld = smp_vld_i;
        if (smp_vld_i) begin
            out_d.l = chan_out[0];
            out_d.r = chan_out[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign smp_vld_o = out_q.vld;
    assign smp_l_o   = out_q.l;
    assign smp_r_o   = out_q.r;

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!smp_vld_i) |-> ($stable(smp_l_o) && $stable(smp_r_o)));

    // R9
    mute_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(smp_vld_i && mute_i) |-> (smp_l_o == '0 && smp_r_o == '0));

    // R3
    sign_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(smp_vld_i && !smp_l_i[SW-1]) |-> !smp_l_o[SW-1]);

    // R2
    vld_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(smp_vld_i) |-> smp_vld_o);

endmodule

// File: tb/test_fade_gain_stage.sv
module test_fade_gain_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld_i = 1'b0;
    logic [19:0] smp_l_i = '0;
    logic [19:0] smp_r_i = '0;
    logic        fade_en_i = 1'b0;
    logic [9:0]  fade_rate_i = '0;
    logic [9:0]  fade_level_i = 10'd1023;
    logic        atten_i = 1'b0;
    logic        mute_i = 1'b0;
    logic        smp_vld_o;
    logic [19:0] smp_l_o;
    logic [19:0] smp_r_o;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_g    = 1023;
    int exp_cnt  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fade_gain_stage i_fade_gain_stage (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld_i),
        .smp_l_i(smp_l_i), .smp_r_i(smp_r_i), .fade_en_i(fade_en_i),
        .fade_rate_i(fade_rate_i), .fade_level_i(fade_level_i),
        .atten_i(atten_i), .mute_i(mute_i), .smp_vld_o(smp_vld_o),
        .smp_l_o(smp_l_o), .smp_r_o(smp_r_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_out(input int s, input int g);
        int q;
        if (mute_i) return 0;
        q = (s * g) / 1024;
        if (atten_i) q = q >>> 2;
        return q;
    endfunction

    function automatic int as_int(input logic [19:0] v);
        return int'($signed(v));
    endfunction

    // Reference ramp: one move per rate strobes while enabled and off target.
    task automatic model_step();
        int re;
        int tgt;
        re  = (fade_rate_i == 0) ? 1 : int'(fade_rate_i);
        tgt = int'(fade_level_i);
        if (!fade_en_i || exp_g == tgt) begin
            exp_cnt = 0;
        end else if (exp_cnt + 1 >= re) begin
            exp_cnt = 0;
            exp_g   = (exp_g < tgt) ? exp_g + 1 : exp_g - 1;
        end else begin
            exp_cnt++;
        end
    endtask

    task automatic send(input int l, input int r, input string req);
        int el;
        int er;
        @(negedge clk);
        smp_l_i = 20'(l);
        smp_r_i = 20'(r);
        smp_vld_i = 1'b1;
        el = expect_out(l, exp_g);
        er = expect_out(r, exp_g);
        model_step();
        @(negedge clk);
        smp_vld_i = 1'b0;
        check(req, int'(smp_vld_o), 1);
        check(req, as_int(smp_l_o), el);
        check(req, as_int(smp_r_o), er);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", int'(smp_vld_o), 0);
        check("R1", as_int(smp_l_o), 0);
        check("R1", as_int(smp_r_o), 0);
        send(261120, -261120, "R1");
    endtask

    task automatic t_hold();
        @(negedge clk);
        smp_l_i = 20'(1234);
        smp_r_i = 20'(-777);
        repeat (3) @(negedge clk);
        check("R2", int'(smp_vld_o), 0);
        check("R2", as_int(smp_l_o), 255 * 1023);
        check("R2", as_int(smp_r_o), -255 * 1023);
    endtask

    task automatic t_round();
        send(3, -3, "R3");
        send(524287, -524288, "R3");
        send(1, 1000, "R3");
    endtask

    task automatic t_ramp_down();
        fade_level_i = 10'd1020;
        fade_rate_i  = 10'd3;
        fade_en_i    = 1'b1;
        for (int i = 0; i < 12; i++) send(261120, -261120, "R4");
        check("R6", exp_g, 1020);
        for (int i = 0; i < 3; i++) send(261120, 5, "R6");
    endtask

    task automatic t_rate_zero();
        fade_rate_i  = 10'd0;
        fade_level_i = 10'd1015;
        for (int i = 0; i < 6; i++) send(261120, -100000, "R5");
    endtask

    task automatic t_ramp_up();
        fade_rate_i  = 10'd2;
        fade_level_i = 10'd1018;
        for (int i = 0; i < 6; i++) send(261120, 261120, "R10");
    endtask

    task automatic t_freeze();
        fade_level_i = 10'd900;
        fade_rate_i  = 10'd1;
        fade_en_i    = 1'b0;
        for (int i = 0; i < 4; i++) send(261120, -261120, "R7");
        fade_en_i = 1'b1;
        send(261120, -261120, "R7");
        send(261120, -261120, "R7");
    endtask

    task automatic t_atten();
        atten_i = 1'b1;
        send(-261120, 261120, "R8");
        send(-5, 7, "R8");
    endtask

    task automatic t_mute();
        mute_i = 1'b1;
        send(261120, -261120, "R9");
        atten_i = 1'b0;
        send(-3000, 3000, "R9");
        mute_i = 1'b0;
        send(261120, -261120, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_round();
        t_ramp_down();
        t_rate_zero();
        t_ramp_up();
        t_freeze();
        t_atten();
        t_mute();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule